// File: doc/BRIEF.md
# Multi-Error Sector Correction Sequencer

This block finishes the correction of one 512-byte sector once an external error locator has done the heavy arithmetic. On a start pulse it looks at the ten stored check bytes and at the four syndrome words. If the check bytes are all ones, the sector is taken as freshly erased and left alone. If the syndromes are all zero, the sector is clean. In every other case the block pulses a request to the locator and then follows the locator's 4-bit correction state through a two-step handshake.

When the locator reports that correction is complete, the block captures up to four error locations with their XOR patterns. It turns each reported location into a byte offset in the sector buffer and patches that byte with one read followed by one write. Locations that land outside the sector are dropped. A single-cycle done pulse ends each run. It carries a status code and the number of bytes that were patched.

Top module: `sector_fix_seq`

## Requirements
- R1: When all ten stored check bytes equal 0xFF, the run ends with status ERASED (code 1) and fix count 0. The locator request never pulses and the buffer is not accessed. This takes priority over the syndrome test.
- R2: When the check bytes are not all 0xFF and all four 10-bit syndrome words are zero, the run ends with status CLEAN (code 0). There is no locator request and no buffer access.
- R3: After the locator request, a correction state in 0..3 is not accepted until a state above 3 has been seen. The run then resolves on the first return of the state into 0..3.
- R4: Each of the two waits lasts at most TIMEOUT polls, one per clock. If a wait expires, the run ends with status TIMEOUT (code 4) and no buffer access.
- R5: A final correction state of 0 ends the run as CLEAN (code 0). A final state of 1 ends it as UNCORRECTABLE (code 3). Neither touches the buffer.
- R6: For a final state of 2 or 3, the 2-bit count field plus one gives the number of errors processed. Errors 0 and 1 sit in bits [9:0] and [25:16] of the first address word, and errors 2 and 3 in the same places of the second. Their XOR values sit in bits [7:0] and [23:16] of the matching value words. Entries beyond the count are ignored.
- R7: The buffer offset is 519 minus the reported address. A fix is applied only when that offset lies in 0..511; otherwise it is dropped.
- R8: Each fix asserts a read for one cycle, and the buffer returns the data in the next cycle. In that next cycle the block writes the read data XOR the error value to the same offset. Reads and writes never overlap, and errors are processed in index order.
- R9: The done signal is a one-cycle pulse. While it is high, status holds the result and fixCount holds the number of bytes written. A completed correction reports status CORRECTED (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing one sector (sampled when idle) |
| storedEcc | input | 80 | Ten stored check bytes, byte 0 in bits [7:0] |
| syndrome | input | 40 | Four 10-bit syndrome words |
| locStart | output | 1 | One-cycle request to start error locating |
| locState | input | 4 | Locator correction state |
| errCountField | input | 2 | Locator error count minus one |
| errAddrLo | input | 32 | Addresses of errors 0 and 1 |
| errAddrHi | input | 32 | Addresses of errors 2 and 3 |
| errValLo | input | 32 | XOR values of errors 0 and 1 |
| errValHi | input | 32 | XOR values of errors 2 and 3 |
| bufRd | output | 1 | Buffer read strobe |
| bufWr | output | 1 | Buffer write strobe |
| bufAddr | output | 9 | Buffer byte offset |
| bufWdata | output | 8 | Buffer write data |
| bufRdata | input | 8 | Buffer read data, valid the cycle after bufRd |
| done | output | 1 | End-of-run pulse |
| status | output | 3 | Result code |
| fixCount | output | 3 | Bytes patched in this run |

## Verification
The hardest situation to reach is a locator whose state is already inside 0..3 when the request goes out, left over from an earlier run. A naive sequencer would take that stale value as an answer. The bench models the locator as a process that keeps the previous state for two cycles after the request, then goes busy for a chosen number of cycles, and only then settles. This shows that completion waits for the busy phase. The same model produces both timeouts: in one it never goes busy, and in the other it never leaves busy. The address corners are 7, 8, 519 and 520, together with two hits on the same byte.

// File: rtl/sector_fix_pkg.sv
package sector_fix_pkg;
  localparam int MAX_ERR = 4;
  localparam int ADDR_W  = 10;
  localparam int VAL_W   = 8;

  typedef enum logic [2:0] {
    ST_CLEAN     = 3'd0,
    ST_ERASED    = 3'd1,
    ST_CORRECTED = 3'd2,
    ST_UNCORR    = 3'd3,
    ST_TIMEOUT   = 3'd4
  } fix_status_t;

  typedef struct packed {
    logic clear;
    logic latchErr;
    logic loadFix;
    logic advance;
    logic countFix;
  } fix_ctl_t;
endpackage

// File: rtl/sector_fix_dp.sv
module sector_fix_dp
  import sector_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 10,
  parameter int SYND_WORDS   = 4,
  parameter int SYND_W       = 10
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fix_ctl_t                        ctl,
  input  logic [ECC_BYTES*8-1:0]          storedEcc,
  input  logic [SYND_WORDS*SYND_W-1:0]    syndrome,
  input  logic [1:0]                      errCountField,
  input  logic [31:0]                     errAddrLo,
  input  logic [31:0]                     errAddrHi,
  input  logic [31:0]                     errValLo,
  input  logic [31:0]                     errValHi,
  input  logic [VAL_W-1:0]                bufRdata,
  output logic                            eccErased,
  output logic                            syndClean,
  output logic                            allDone,
  output logic                            curInRange,
  output logic [$clog2(SECTOR_BYTES)-1:0] bufAddr,
  output logic [VAL_W-1:0]                bufWdata,
  output logic [$clog2(MAX_ERR+1)-1:0]    fixCount
);
  localparam int OFF_W = $clog2(SECTOR_BYTES);
  localparam int IDX_W = $clog2(MAX_ERR + 1);
  localparam int SEL_W = $clog2(MAX_ERR);
  localparam int BIAS  = SECTOR_BYTES + 7;

  logic [ADDR_W-1:0] addrIn [MAX_ERR];
  logic [VAL_W-1:0]  valIn  [MAX_ERR];
  logic [ADDR_W-1:0] addrQ  [MAX_ERR];
  logic [VAL_W-1:0]  valQ   [MAX_ERR];
  logic [IDX_W-1:0]  idx, numErr, fixCnt;
  logic [OFF_W-1:0]  offQ;
  logic [VAL_W-1:0]  valCur;
  logic [ADDR_W-1:0] selAddr;
  logic [ADDR_W:0]   diff;

  // unpack two entries per 32-bit word, low half first
  for (genvar g = 0; g < MAX_ERR; g++) begin : g_unpack
    localparam int SH = 16 * (g % 2);
    if (g < 2) begin : g_lo
      assign addrIn[g] = errAddrLo[SH +: ADDR_W];
      assign valIn[g]  = errValLo[SH +: VAL_W];
    end else begin : g_hi
      assign addrIn[g] = errAddrHi[SH +: ADDR_W];
      assign valIn[g]  = errValHi[SH +: VAL_W];
    end
  end

  assign eccErased = &storedEcc;
  assign syndClean = (syndrome == '0);

  assign selAddr    = addrQ[idx[SEL_W-1:0]];
  assign diff       = (ADDR_W+1)'(BIAS) - {1'b0, selAddr};
  assign curInRange = ({1'b0, selAddr} <= (ADDR_W+1)'(BIAS)) &&
                      (diff < (ADDR_W+1)'(SECTOR_BYTES));
  assign allDone    = (idx == numErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx    <= '0;
      numErr <= '0;
      fixCnt <= '0;
      offQ   <= '0;
      valCur <= '0;
      for (int i = 0; i < MAX_ERR; i++) begin
        addrQ[i] <= '0;
        valQ[i]  <= '0;
      end
    end else begin
      if (ctl.clear) begin
        idx    <= '0;
        fixCnt <= '0;
        numErr <= '0;
      end
      if (ctl.latchErr) begin
        numErr <= IDX_W'(errCountField) + IDX_W'(1);
        for (int i = 0; i < MAX_ERR; i++) begin
          addrQ[i] <= addrIn[i];
          valQ[i]  <= valIn[i];
        end
      end
      if (ctl.loadFix) begin
        offQ   <= diff[OFF_W-1:0];
        valCur <= valQ[idx[SEL_W-1:0]];
      end
      if (ctl.advance)  idx    <= idx + IDX_W'(1);
      if (ctl.countFix) fixCnt <= fixCnt + IDX_W'(1);
    end
  end

  assign bufAddr  = offQ;
  assign bufWdata = bufRdata ^ valCur;
  assign fixCount = fixCnt;

  // a run never writes more bytes than it was told to process
  assert_fix_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fixCnt <= numErr);
  // a captured fix always targets a byte inside the sector
  assert_offset_in_sector_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFix |=> ({2'b0, offQ} == (ADDR_W+1)'(BIAS) - {1'b0, $past(selAddr)}));
endmodule

// File: rtl/sector_fix_ctrl.sv
module sector_fix_ctrl
  import sector_fix_pkg::*;
#(
  parameter int TIMEOUT = 10240
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  locState,
  input  logic        eccErased,
  input  logic        syndClean,
  input  logic        allDone,
  input  logic        curInRange,
  output fix_ctl_t    ctl,
  output logic        locStart,
  output logic        bufRd,
  output logic        bufWr,
  output logic        done,
  output fix_status_t status
);
  localparam int TMO_W = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT_HI, S_WAIT_LO, S_SEL, S_RD, S_WR} fsm_t;

  fsm_t        state, nextState;
  logic [TMO_W-1:0] tmo, tmoNext;
  logic        finish, locStartNext;
  fix_status_t finStatus;
  logic        stateLow, tmoLast;

  assign stateLow = (locState <= 4'd3);
  assign tmoLast  = (tmo == TMO_W'(TIMEOUT - 1));

  always_comb begin
    nextState    = state;
    tmoNext      = tmo;
    ctl          = '0;
    finish       = 1'b0;
    finStatus    = ST_CLEAN;
    locStartNext = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.clear = 1'b1;
        tmoNext   = '0;
        if (eccErased) begin
          finish = 1'b1; finStatus = ST_ERASED;
        end else if (syndClean) begin
          finish = 1'b1; finStatus = ST_CLEAN;
        end else begin
          locStartNext = 1'b1;
          nextState    = S_WAIT_HI;
        end
      end
      S_WAIT_HI: begin
        if (!stateLow) begin
          nextState = S_WAIT_LO;
          tmoNext   = '0;
        end else if (tmoLast) begin
          finish = 1'b1; finStatus = ST_TIMEOUT; nextState = S_IDLE;
        end else tmoNext = tmo + TMO_W'(1);
      end
      S_WAIT_LO: begin
        if (stateLow) begin
          unique case (locState[1:0])
            2'd0: begin finish = 1'b1; finStatus = ST_CLEAN;  nextState = S_IDLE; end
            2'd1: begin finish = 1'b1; finStatus = ST_UNCORR; nextState = S_IDLE; end
            default: begin ctl.latchErr = 1'b1; nextState = S_SEL; end
          endcase
        end else if (tmoLast) begin
          finish = 1'b1; finStatus = ST_TIMEOUT; nextState = S_IDLE;
        end else tmoNext = tmo + TMO_W'(1);
      end
      S_SEL: begin
        if (allDone) begin
          finish = 1'b1; finStatus = ST_CORRECTED; nextState = S_IDLE;
        end else begin
          ctl.advance = 1'b1;
          if (curInRange) begin
            ctl.loadFix = 1'b1;
            nextState   = S_RD;
          end
        end
      end
      S_RD: nextState = S_WR;
      S_WR: begin
        ctl.countFix = 1'b1;
        nextState    = S_SEL;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tmo      <= '0;
      done     <= 1'b0;
      status   <= ST_CLEAN;
      locStart <= 1'b0;
    end else begin
      state    <= nextState;
      tmo      <= tmoNext;
      done     <= finish;
      locStart <= locStartNext;
      if (finish) status <= finStatus;
    end
  end

  assign bufRd = (state == S_RD);
  assign bufWr = (state == S_WR);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(bufRd && bufWr));
  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufWr) |-> $past(bufRd));
  assert_erased_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && eccErased) |=> (done && status == ST_ERASED && !locStart));
  assert_timeout_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    tmo < TMO_W'(TIMEOUT));
  assert_code_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (status <= ST_TIMEOUT));
endmodule

// File: rtl/sector_fix_seq.sv
module sector_fix_seq
  import sector_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 10,
  parameter int SYND_WORDS   = 4,
  parameter int SYND_W       = 10,
  parameter int TIMEOUT      = 10240
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [ECC_BYTES*8-1:0]       storedEcc,
  input  logic [SYND_WORDS*SYND_W-1:0] syndrome,
  output logic                         locStart,
  input  logic [3:0]                   locState,
  input  logic [1:0]                   errCountField,
  input  logic [31:0]                  errAddrLo,
  input  logic [31:0]                  errAddrHi,
  input  logic [31:0]                  errValLo,
  input  logic [31:0]                  errValHi,
  output logic                         bufRd,
  output logic                         bufWr,
  output logic [$clog2(SECTOR_BYTES)-1:0] bufAddr,
  output logic [7:0]                   bufWdata,
  input  logic [7:0]                   bufRdata,
  output logic                         done,
  output logic [2:0]                   status,
  output logic [2:0]                   fixCount
);
  fix_ctl_t    ctl;
  fix_status_t statusE;
  logic eccErased, syndClean, allDone, curInRange;

  sector_fix_ctrl #(.TIMEOUT(TIMEOUT)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .locState(locState),
    .eccErased(eccErased), .syndClean(syndClean), .allDone(allDone),
    .curInRange(curInRange), .ctl(ctl), .locStart(locStart),
    .bufRd(bufRd), .bufWr(bufWr), .done(done), .status(statusE)
  );

  sector_fix_dp #(
    .SECTOR_BYTES(SECTOR_BYTES), .ECC_BYTES(ECC_BYTES),
    .SYND_WORDS(SYND_WORDS), .SYND_W(SYND_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .storedEcc(storedEcc),
    .syndrome(syndrome), .errCountField(errCountField),
    .errAddrLo(errAddrLo), .errAddrHi(errAddrHi),
    .errValLo(errValLo), .errValHi(errValHi), .bufRdata(bufRdata),
    .eccErased(eccErased), .syndClean(syndClean), .allDone(allDone),
    .curInRange(curInRange), .bufAddr(bufAddr), .bufWdata(bufWdata),
    .fixCount(fixCount)
  );

  assign status = statusE;
endmodule

// File: tb/test_sector_fix_seq.sv
module test_sector_fix_seq;
  localparam int TMO = 40;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [79:0] storedEcc = '0;
  logic [39:0] syndrome = '0;
  logic locStart;
  logic [3:0] locState = 4'd0;
  logic [1:0] errCountField = '0;
  logic [31:0] errAddrLo = '0, errAddrHi = '0, errValLo = '0, errValHi = '0;
  logic bufRd, bufWr, done;
  logic [8:0] bufAddr;
  logic [7:0] bufWdata, bufRdata;
  logic [2:0] status, fixCount;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [512];
  logic [7:0] refMem [512];
  logic [16:0] expQ [$];

  always #2 clk = ~clk;

  sector_fix_seq #(.TIMEOUT(TMO)) i_sector_fix_seq (
    .clk(clk), .rstN(rstN), .start(start), .storedEcc(storedEcc),
    .syndrome(syndrome), .locStart(locStart), .locState(locState),
    .errCountField(errCountField), .errAddrLo(errAddrLo), .errAddrHi(errAddrHi),
    .errValLo(errValLo), .errValHi(errValHi), .bufRd(bufRd), .bufWr(bufWr),
    .bufAddr(bufAddr), .bufWdata(bufWdata), .bufRdata(bufRdata),
    .done(done), .status(status), .fixCount(fixCount)
  );

  // sector buffer with one-cycle read latency
  always @(posedge clk) begin
    if (bufRd) bufRdata <= mem[bufAddr];
    if (bufWr) mem[bufAddr] <= bufWdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every clock: writes must match the reference queue (R7, R8)
  always @(negedge clk) begin
    cycles++;
    if (rstN && bufWr) begin
      if (expQ.size() == 0) check(1'b0, "R7 unexpected write addr", int'(bufAddr), -1);
      else begin
        logic [16:0] e;
        e = expQ.pop_front();
        check(bufAddr == e[16:8], "R7 write offset", int'(bufAddr), int'(e[16:8]));
        check(bufWdata == e[7:0], "R8 write data", int'(bufWdata), int'(e[7:0]));
      end
    end
    if (rstN && bufRd && bufWr) check(1'b0, "R8 read and write together", 1, 0);
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // reference: queue expected writes in index order for states 2/3
  task automatic buildRef(input int cnt);
    for (int i = 0; i <= cnt; i++) begin
      logic [31:0] aw, vw;
      int a, off;
      logic [7:0] v;
      aw = (i < 2) ? errAddrLo : errAddrHi;
      vw = (i < 2) ? errValLo : errValHi;
      a  = int'(aw[16*(i%2) +: 10]);
      v  = vw[16*(i%2) +: 8];
      off = 519 - a;
      if (off >= 0 && off < 512) begin
        refMem[off] = refMem[off] ^ v;
        expQ.push_back({9'(off), refMem[off]});
      end
    end
  endtask

  task automatic runCase(input string tag, input logic [79:0] ecc, input logic [39:0] syn,
                         input logic [3:0] pre, input int busyLen, input logic [3:0] fin,
                         input logic [1:0] cnt, input logic [31:0] aLo, input logic [31:0] aHi,
                         input logic [31:0] vLo, input logic [31:0] vHi,
                         input int expStatus, input int expFix, input bit expLoc);
    int k = -1;
    bit seenLoc = 1'b0, seenDone = 1'b0;
    @(negedge clk);
    storedEcc = ecc; syndrome = syn; locState = pre; errCountField = cnt;
    errAddrLo = aLo; errAddrHi = aHi; errValLo = vLo; errValHi = vHi;
    if (expStatus == 2) buildRef(int'(cnt));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000 && !seenDone; c++) begin
      if (locStart) begin seenLoc = 1'b1; k = 0; end
      if (done) begin
        seenDone = 1'b1;
        check(status == 3'(expStatus), {tag, " status"}, int'(status), expStatus);
        check(fixCount == 3'(expFix), {"R9 fixCount ", tag}, int'(fixCount), expFix);
      end else begin
        if (k >= 0) begin
          if (k < 2 || busyLen < 0) locState = pre;
          else if (k < 2 + busyLen) locState = 4'hC;
          else locState = fin;
          k++;
        end
        @(negedge clk);
      end
    end
    check(seenDone, {"R9 done seen ", tag}, int'(seenDone), 1);
    check(seenLoc == expLoc, {tag, " locator request"}, int'(seenLoc), int'(expLoc));
    @(negedge clk);
    check(expQ.size() == 0, {tag, " pending writes"}, expQ.size(), 0);
    expQ.delete();
    for (int i = 0; i < 512; i++) refMem[i] = mem[i];
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!done && !bufRd && !bufWr && !locStart, "R9 reset outputs", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && status == 3'd0, "R9 idle after reset", int'(status), 0);

    // R1: erased page, nonzero syndrome still bypassed
    runCase("R1 erased", {80{1'b1}}, 40'h1234, 4'd3, 3, 4'd2, 2'd0,
            32'd100, 0, 32'h11, 0, 1, 0, 1'b0);
    // R2: one check byte not 0xFF and zero syndromes
    runCase("R2 clean syndrome", {8'hFE, {72{1'b1}}}, 40'h0, 4'd3, 3, 4'd2, 2'd0,
            32'd100, 0, 32'h11, 0, 0, 0, 1'b0);
    // R3 R6 R7: stale state 3 before busy; 519->0, 8->511, 5 and 600 dropped
    runCase("R3 R6 four errors", 80'h1, 40'h5, 4'd3, 5, 4'd2, 2'd3,
            {6'd0, 10'd8, 6'd0, 10'd519}, {6'd0, 10'd600, 6'd0, 10'd5},
            {8'd0, 8'hA5, 8'd0, 8'h5A}, {8'd0, 8'h22, 8'd0, 8'h11}, 2, 2, 1'b1);
    // R8: two hits on one byte, state 3
    runCase("R8 same byte twice", 80'h2, 40'h7, 4'd0, 2, 4'd3, 2'd1,
            {6'd0, 10'd300, 6'd0, 10'd300}, 0,
            {8'd0, 8'hF0, 8'd0, 8'h0F}, 0, 2, 2, 1'b1);
    // R6: count field 0 ignores the other entries
    runCase("R6 single error", 80'h3, 40'h9, 4'd1, 1, 4'd2, 2'd0,
            {6'd0, 10'd200, 6'd0, 10'd400}, {6'd0, 10'd250, 6'd0, 10'd260},
            {8'd0, 8'h77, 8'd0, 8'h3C}, {8'd0, 8'h66, 8'd0, 8'h55}, 2, 1, 1'b1);
    // R7: addresses 7 and 520 both outside the sector
    runCase("R7 boundaries dropped", 80'h4, 40'h1, 4'd0, 3, 4'd2, 2'd1,
            {6'd0, 10'd520, 6'd0, 10'd7}, 0,
            {8'd0, 8'hFF, 8'd0, 8'hFF}, 0, 2, 0, 1'b1);
    // R5: uncorrectable and no-error final states
    runCase("R5 uncorrectable", 80'h5, 40'h3, 4'd2, 4, 4'd1, 2'd3,
            {6'd0, 10'd100, 6'd0, 10'd101}, 0, 32'h00110022, 0, 3, 0, 1'b1);
    runCase("R5 no error", 80'h6, 40'h3, 4'd2, 4, 4'd0, 2'd3,
            {6'd0, 10'd100, 6'd0, 10'd101}, 0, 32'h00110022, 0, 0, 0, 1'b1);
    // R4: never leaves 0..3, then never returns
    runCase("R4 timeout first wait", 80'h7, 40'h3, 4'd2, -1, 4'd2, 2'd0,
            32'd100, 0, 32'h11, 0, 4, 0, 1'b1);
    runCase("R4 timeout second wait", 80'h8, 40'h3, 4'd0, 1000, 4'd2, 2'd0,
            32'd100, 0, 32'h11, 0, 4, 0, 1'b1);

    // buffer contents against the reference
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== refMem[i]) bad++;
      check(bad == 0, "R8 buffer contents", bad, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule